// File: doc/BRIEF.md
# DSP Math Error Detector

This block watches the outcome of each arithmetic step of a DSP datapath and decides whether that step must raise a math error trap. It covers four kinds of fault:

- ordinary overflow of a 40-bit accumulator past bit 31 into its guard bits;
- catastrophic overflow out of bit 39;
- a divide with a zero divisor;
- a shift whose signed amount is out of range.

The datapath does the arithmetic. Once per operation it presents a strobe, an operation code and the values this block needs:

- the sign bits of the accumulator before the step and of the operand;
- bits 39:31 of the result;
- the divisor;
- the signed shift amount.

Six sticky status flags record every detected fault, whether or not a trap is enabled. Software clears them with a write-one-to-clear strobe. Two enables gate whether accumulator faults become traps. For guard-bit overflow, `ovf_trap_en` alone decides. For catastrophic overflow, `cat_trap_en` must be set and all three saturation modes must be off. Divide-by-zero and a bad shift always trap.

The trap request comes from a two-state machine. `ST_IDLE` moves to `ST_TRAP` on transition T_RAISE, when an offending operation is sampled. `ST_TRAP` stays in `ST_TRAP` on T_RERAISE, when another offending operation is sampled. Otherwise `ST_TRAP` returns to `ST_IDLE` on T_DONE. `trap_req` is high exactly while the machine is in `ST_TRAP`.

Top module: `dsp_math_fault`

## Requirements
- R1: After reset, `flags` is 6'h00 and `trap_req` is 0.
- R2: For an accumulator operation (`op_kind` 0 = accumulator A, 1 = accumulator B) whose `acc_res_hi` (result bits 39:31) is neither all zeros nor all ones:
  - flag bit 0 (A) or bit 1 (B) is set;
  - a trap is requested only if `ovf_trap_en` is 1.
- R3: A divide (`op_kind` 2) with `divisor` equal to zero sets flag bit 4 and requests a trap, whatever the configuration.
- R4: An accumulator operation is catastrophic when `acc_pre_sign` equals `acc_opnd_sign` and bit 39 of the result differs from `acc_pre_sign`. Such an operation:
  - sets flag bit 2 (A) or bit 3 (B);
  - requests a trap if `cat_trap_en` is 1 and `sat_a_en`, `sat_b_en` and `sat_wr_en` are all 0.
- R5: If any of the three saturation enables is 1, a catastrophic overflow still sets its flag but requests no trap.
- R6: A shift (`op_kind` 3) whose signed `shift_amt` is below -16 or above +16 sets flag bit 5 and requests a trap. Amounts from -16 to +16 have no effect.
- R7: `trap_req` timing:
  - it is high in the cycle after an offending operation is sampled with `op_valid` high, one cycle per offending operation;
  - it is low after a cycle with `op_valid` low or with `op_kind` 4 to 7.
- R8: Flags are sticky until a cycle with `clr_en` high clears every bit set in `clr_mask`. A flag set and cleared in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation's results are presented this cycle |
| op_kind | input | 3 | 0 acc A, 1 acc B, 2 divide, 3 shift, others unused |
| acc_pre_sign | input | 1 | Bit 39 of the accumulator before the step |
| acc_opnd_sign | input | 1 | Bit 39 of the operand added to it |
| acc_res_hi | input | 9 | Bits 39:31 of the accumulator result |
| divisor | input | 16 | Divisor of a divide operation |
| shift_amt | input | 6 | Signed shift amount |
| ovf_trap_en | input | 1 | Trap on guard-bit overflow |
| cat_trap_en | input | 1 | Trap on catastrophic overflow |
| sat_a_en | input | 1 | Saturation mode for accumulator A |
| sat_b_en | input | 1 | Saturation mode for accumulator B |
| sat_wr_en | input | 1 | Saturation mode on data write-back |
| clr_en | input | 1 | Flag clear strobe |
| clr_mask | input | 6 | Flags to clear (one bit per flag) |
| flags | output | 6 | Sticky fault flags |
| trap_req | output | 1 | Math error trap request |

## Verification
Every result is due one clock edge after the cycle that presents the operation: both the flag update and the `trap_req` pulse. The pulse must be gone one edge later when no new offence arrives. The bench drives each operation on a falling edge and removes it on the next falling edge. It checks flags and `trap_req` at that second falling edge, which follows exactly one rising edge. It then checks `trap_req` again one cycle later for the pulse's end. Clears are checked one falling edge after the clear strobe.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
    localparam int OPK_W = 3;
    localparam logic [OPK_W-1:0] OPK_ACC_A = 3'd0;
    localparam logic [OPK_W-1:0] OPK_ACC_B = 3'd1;
    localparam logic [OPK_W-1:0] OPK_DIV   = 3'd2;
    localparam logic [OPK_W-1:0] OPK_SHIFT = 3'd3;

    localparam int FLAG_N    = 6;
    localparam int FL_OVF_A  = 0;
    localparam int FL_OVF_B  = 1;
    localparam int FL_CAT_A  = 2;
    localparam int FL_CAT_B  = 3;
    localparam int FL_DIV0   = 4;
    localparam int FL_SHIFT  = 5;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_TRAP = 1'b1
    } trap_state_e;
endpackage

// File: rtl/dmf_acc_check.sv
// Classifies one accumulator result: guard-bit overflow and catastrophic overflow.
module dmf_acc_check #(
    parameter int GUARD_W = 9
) (
    input  logic               pre_sign,
    input  logic               opnd_sign,
    input  logic [GUARD_W-1:0] res_hi,
    output logic               guard_ovf,
    output logic               cat_ovf
);
    logic all_zero;
    logic all_one;

    always_comb begin
        all_zero  = (res_hi == '0);
        all_one   = (res_hi == '1);
        // Bits above the low word disagree: guard bits are in use.
        guard_ovf = !(all_zero || all_one);
        // Like-signed inputs produced a result of the other sign.
        cat_ovf   = (pre_sign == opnd_sign) && (res_hi[GUARD_W-1] != pre_sign);
    end
endmodule

// File: rtl/dmf_range_check.sv
// Divisor-zero and shift-amount range detection.
module dmf_range_check #(
    parameter int DIV_W     = 16,
    parameter int SHF_W     = 6,
    parameter int SHIFT_MAX = 16
) (
    input  logic [DIV_W-1:0]        divisor,
    input  logic signed [SHF_W-1:0] shift_amt,
    output logic                    div_zero,
    output logic                    shift_bad
);
    int amt;

    always_comb begin
        amt       = int'(shift_amt);
        div_zero  = (divisor == '0);
        shift_bad = (amt > SHIFT_MAX) || (amt < -SHIFT_MAX);
    end
endmodule

// File: rtl/dmf_flag_bank.sv
// Sticky write-one-to-clear flags; a set wins over a clear in the same cycle.
module dmf_flag_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         clr_en,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (set_vec[i])
                flags[i] <= 1'b1;
            else if (clr_en && clr_mask[i])
                flags[i] <= 1'b0;
        end

        // R8: a flag holds unless it is cleared.
        p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !(clr_en && clr_mask[i])) |=> flags[i]);

        // R8: a clear with no simultaneous set empties the flag.
        p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en && clr_mask[i] && !set_vec[i]) |=> !flags[i]);
    end
endmodule

// File: rtl/dsp_math_fault.sv
module dsp_math_fault
    import dmf_pkg::*;
#(
    parameter int ACC_W     = 40,
    parameter int LOW_W     = 32,
    parameter int DIV_W     = 16,
    parameter int SHF_W     = 6,
    parameter int SHIFT_MAX = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     op_valid,
    input  logic [2:0]               op_kind,
    input  logic                     acc_pre_sign,
    input  logic                     acc_opnd_sign,
    input  logic [ACC_W-LOW_W:0]     acc_res_hi,
    input  logic [DIV_W-1:0]         divisor,
    input  logic signed [SHF_W-1:0]  shift_amt,
    input  logic                     ovf_trap_en,
    input  logic                     cat_trap_en,
    input  logic                     sat_a_en,
    input  logic                     sat_b_en,
    input  logic                     sat_wr_en,
    input  logic                     clr_en,
    input  logic [5:0]               clr_mask,
    output logic [5:0]               flags,
    output logic                     trap_req
);
    localparam int GUARD_W = ACC_W - LOW_W + 1;

    trap_state_e state, nxt;

    logic guard_ovf, cat_ovf, div_zero, shift_bad;
    logic is_acc, is_b, is_div, is_shf, sat_off, raise;
    logic [FLAG_N-1:0] set_vec;

    dmf_acc_check #(.GUARD_W(GUARD_W)) u_acc (
        .pre_sign  (acc_pre_sign),
        .opnd_sign (acc_opnd_sign),
        .res_hi    (acc_res_hi),
        .guard_ovf (guard_ovf),
        .cat_ovf   (cat_ovf)
    );

    dmf_range_check #(.DIV_W(DIV_W), .SHF_W(SHF_W), .SHIFT_MAX(SHIFT_MAX)) u_rng (
        .divisor   (divisor),
        .shift_amt (shift_amt),
        .div_zero  (div_zero),
        .shift_bad (shift_bad)
    );

    always_comb begin
        is_b    = (op_kind == OPK_ACC_B);
        is_acc  = op_valid && ((op_kind == OPK_ACC_A) || is_b);
        is_div  = op_valid && (op_kind == OPK_DIV);
        is_shf  = op_valid && (op_kind == OPK_SHIFT);
        sat_off = !(sat_a_en || sat_b_en || sat_wr_en);

        set_vec           = '0;
        set_vec[FL_OVF_A] = is_acc && !is_b && guard_ovf;
        set_vec[FL_OVF_B] = is_acc &&  is_b && guard_ovf;
        set_vec[FL_CAT_A] = is_acc && !is_b && cat_ovf;
        set_vec[FL_CAT_B] = is_acc &&  is_b && cat_ovf;
        set_vec[FL_DIV0]  = is_div && div_zero;
        set_vec[FL_SHIFT] = is_shf && shift_bad;

        raise = (is_acc && ovf_trap_en && guard_ovf)
             || (is_acc && cat_trap_en && cat_ovf && sat_off)
             || set_vec[FL_DIV0]
             || set_vec[FL_SHIFT];
    end

    dmf_flag_bank #(.N(FLAG_N)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_en   (clr_en),
        .clr_mask (clr_mask),
        .flags    (flags)
    );

    // Next-state logic.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = raise ? ST_TRAP : ST_IDLE;        // T_RAISE
            ST_TRAP: nxt = raise ? ST_TRAP : ST_IDLE;        // T_RERAISE / T_DONE
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // Output process.
    always_comb begin
        trap_req = (state == ST_TRAP);
    end

    // R3: zero divisor traps and flags.
    p_div_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 3'd2 && divisor == '0) |=> (trap_req && flags[4]));

    // R6: out-of-range shift traps.
    p_shift_bad_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 3'd3 && (int'(shift_amt) > SHIFT_MAX || int'(shift_amt) < -SHIFT_MAX))
        |=> (trap_req && flags[5]));

    // R5: any saturation mode silences accumulator traps when guard trapping is off.
    p_sat_blocks_cat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind <= 3'd1 && !ovf_trap_en && (sat_a_en || sat_b_en || sat_wr_en))
        |=> !trap_req);

    // R4: catastrophic overflow with saturation off and enable on traps.
    p_cat_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind <= 3'd1 && cat_trap_en && !sat_a_en && !sat_b_en && !sat_wr_en
         && acc_pre_sign == acc_opnd_sign && acc_res_hi[GUARD_W-1] != acc_pre_sign)
        |=> trap_req);

    // R7: no valid operation, no trap in the following cycle.
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !trap_req);

    // R2: guard-bit overflow on accumulator A is recorded.
    p_guard_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 3'd0 && acc_res_hi != '0 && acc_res_hi != '1) |=> flags[0]);
endmodule

// File: tb/dsp_math_fault_bench.sv
`timescale 1ns/1ps
module dsp_math_fault_bench;
    logic clk = 1'b0;
    logic rst_n;
    logic op_valid;
    logic [2:0] op_kind;
    logic acc_pre_sign, acc_opnd_sign;
    logic [8:0] acc_res_hi;
    logic [15:0] divisor;
    logic signed [5:0] shift_amt;
    logic ovf_trap_en, cat_trap_en, sat_a_en, sat_b_en, sat_wr_en;
    logic clr_en;
    logic [5:0] clr_mask;
    logic [5:0] flags;
    logic trap_req;

    int n_chk = 0;
    int n_fail = 0;
    logic [39:0] vals [8];

    always #2 clk = ~clk;

    dsp_math_fault u_dsp_math_fault (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .acc_pre_sign(acc_pre_sign), .acc_opnd_sign(acc_opnd_sign), .acc_res_hi(acc_res_hi),
        .divisor(divisor), .shift_amt(shift_amt), .ovf_trap_en(ovf_trap_en),
        .cat_trap_en(cat_trap_en), .sat_a_en(sat_a_en), .sat_b_en(sat_b_en),
        .sat_wr_en(sat_wr_en), .clr_en(clr_en), .clr_mask(clr_mask),
        .flags(flags), .trap_req(trap_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        op_valid = 0; op_kind = 3'd0; acc_pre_sign = 0; acc_opnd_sign = 0;
        acc_res_hi = '0; divisor = 16'd1; shift_amt = '0; clr_en = 0; clr_mask = '0;
    endtask

    // Presents one operation for one cycle; on return the single edge has passed.
    task automatic present(input logic [2:0] k, input logic [39:0] pre, input logic [39:0] opnd,
                           input logic [15:0] dv, input logic signed [5:0] sa);
        logic [39:0] res;
        res = pre + opnd;
        @(negedge clk);
        op_valid = 1; op_kind = k; acc_pre_sign = pre[39]; acc_opnd_sign = opnd[39];
        acc_res_hi = res[39:31]; divisor = dv; shift_amt = sa;
        @(negedge clk);
        op_valid = 0;
    endtask

    task automatic clear_all();
        clr_en = 1; clr_mask = 6'h3f;
        @(negedge clk);
        clr_en = 0; clr_mask = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        vals[0] = 40'h00_0000_0000; vals[1] = 40'h00_7FFF_FFFF;
        vals[2] = 40'hFF_8000_0000; vals[3] = 40'h00_0000_0001;
        vals[4] = 40'hFF_FFFF_FFFF; vals[5] = 40'h7F_FFFF_FFFF;
        vals[6] = 40'h80_0000_0000; vals[7] = 40'hC0_0000_0000;
        idle_inputs();
        ovf_trap_en = 0; cat_trap_en = 0; sat_a_en = 0; sat_b_en = 0; sat_wr_en = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        check("R1 flags", {26'd0, flags}, 32'h0);
        check("R1 trap", {31'd0, trap_req}, 32'h0);
        rst_n = 1;
        @(negedge clk);

        // R2 R4 R5 R7: accumulator sweep over values, targets and configurations.
        for (int cfg = 0; cfg < 32; cfg++) begin
            ovf_trap_en = cfg[0]; cat_trap_en = cfg[1];
            sat_a_en = cfg[2]; sat_b_en = cfg[3]; sat_wr_en = cfg[4];
            for (int t = 0; t < 2; t++) begin
                for (int i = 0; i < 8; i++) begin
                    for (int j = 0; j < 8; j++) begin
                        logic [39:0] r;
                        logic g, c, tr;
                        logic [5:0] ef;
                        r  = vals[i] + vals[j];
                        g  = !(r[39:31] == 9'h000 || r[39:31] == 9'h1ff);
                        c  = (vals[i][39] == vals[j][39]) && (r[39] != vals[i][39]);
                        tr = (cfg[0] && g) || (cfg[1] && c && cfg[4:2] == 3'b000);
                        ef = '0;
                        ef[t]     = g;
                        ef[2 + t] = c;
                        present(3'(t), vals[i], vals[j], 16'd1, 6'sd0);
                        check(c ? "R4 R5 acc trap" : "R2 acc trap", {31'd0, trap_req}, {31'd0, tr});
                        check("R2 R4 acc flags", {26'd0, flags}, {26'd0, ef});
                        clear_all();
                        check("R7 pulse ends", {31'd0, trap_req}, 32'h0);
                        check("R8 cleared", {26'd0, flags}, 32'h0);
                    end
                end
            end
        end
        ovf_trap_en = 0; cat_trap_en = 0; sat_a_en = 0; sat_b_en = 0; sat_wr_en = 0;

        // R3: divisor sweep.
        for (int d = 0; d < 300; d++) begin
            logic z;
            z = (d == 0);
            present(3'd2, '0, '0, 16'(d), 6'sd0);
            check("R3 div trap", {31'd0, trap_req}, {31'd0, z});
            check("R3 div flag", {26'd0, flags}, {26'd0, z, 4'd0});
            clear_all();
        end
        present(3'd2, '0, '0, 16'hFFFF, 6'sd0);
        check("R3 div max", {31'd0, trap_req}, 32'h0);
        clear_all();

        // R6: every signed shift amount.
        for (int s = -32; s < 32; s++) begin
            logic b;
            b = (s > 16) || (s < -16);
            present(3'd3, '0, '0, 16'd1, 6'(s));
            check("R6 shift trap", {31'd0, trap_req}, {31'd0, b});
            check("R6 shift flag", {26'd0, flags}, {26'd0, b, 5'd0});
            clear_all();
        end

        // R7: unused kinds and an idle cycle carrying bad values do nothing.
        for (int k = 4; k < 8; k++) begin
            present(3'(k), 40'h7F_FFFF_FFFF, 40'h7F_FFFF_FFFF, 16'd0, 6'sd31);
            check("R7 unused kind trap", {31'd0, trap_req}, 32'h0);
            check("R7 unused kind flags", {26'd0, flags}, 32'h0);
        end
        @(negedge clk);
        op_valid = 0; op_kind = 3'd2; divisor = 16'd0;
        @(negedge clk);
        check("R7 invalid op trap", {31'd0, trap_req}, 32'h0);
        check("R7 invalid op flags", {26'd0, flags}, 32'h0);
        idle_inputs();

        // R7: back-to-back offences keep the request high one cycle each.
        @(negedge clk);
        op_valid = 1; op_kind = 3'd2; divisor = 16'd0;
        @(negedge clk);
        check("R7 first of pair", {31'd0, trap_req}, 32'h1);
        @(negedge clk);
        op_valid = 0;
        check("R7 second of pair", {31'd0, trap_req}, 32'h1);
        @(negedge clk);
        check("R7 pair ends", {31'd0, trap_req}, 32'h0);
        idle_inputs();
        clear_all();

        // R8: set all six flags, then clear with every mask.
        for (int m = 0; m < 64; m++) begin
            present(3'd0, 40'h00_7FFF_FFFF, 40'h1, 16'd1, 6'sd0);
            present(3'd1, 40'h00_7FFF_FFFF, 40'h1, 16'd1, 6'sd0);
            present(3'd0, 40'h80_0000_0000, 40'h80_0000_0000, 16'd1, 6'sd0);
            present(3'd1, 40'h80_0000_0000, 40'h80_0000_0000, 16'd1, 6'sd0);
            present(3'd2, '0, '0, 16'd0, 6'sd0);
            present(3'd3, '0, '0, 16'd1, 6'sd20);
            @(negedge clk);
            check("R8 all set sticky", {26'd0, flags}, 32'h3f);
            clr_en = 1; clr_mask = 6'(m);
            @(negedge clk);
            clr_en = 0;
            check("R8 masked clear", {26'd0, flags}, {26'd0, 6'h3f & ~6'(m)});
            clear_all();
        end

        // R8: set wins over a same-cycle clear.
        @(negedge clk);
        op_valid = 1; op_kind = 3'd2; divisor = 16'd0; clr_en = 1; clr_mask = 6'h10;
        @(negedge clk);
        idle_inputs();
        check("R8 set beats clear", {26'd0, flags}, 32'h10);
        clear_all();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule